// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is one bank of sixteen general-purpose pins behind a simple synchronous register port. Each pin can either drive a push-pull output or be sampled as an input. Each pin also carries one alternate-function select bit that goes straight out to an external pad multiplexer. Inputs pass through a two-stage synchronizer. The synchronized level can be read back, and it feeds a per-pin trigger detector.

Each input pin can latch an interrupt on a rising edge, a falling edge, a high level or a low level. Three per-pin registers choose the trigger: one picks edge or level, one picks the edge polarity and one picks the level polarity. Latched bits collect in a pending register. Software clears that register by writing to it: the written value is ANDed in, so writing zero clears every bit. A mask register gates the pending bits onto one summary interrupt line, which feeds a higher-level aggregator. Software that needs both-edge detection flips the edge polarity after each event.

Top module: `gpio_irq_bank`

## Requirements
- R1: Register addresses on `reg_addr` are 0 direction, 1 output data, 2 pin level (read-only), 3 alternate select, 4 mask, 5 trigger type, 6 edge polarity, 7 level polarity and 8 pending. Reads are combinational from `reg_addr`. After reset, mask and trigger type read 16'hFFFF and every other register reads 0.
- R2: A write to direction or output data takes effect on the next clock edge. `pad_oe` follows the direction register (1 means output) and `pad_out` follows the output data register.
- R3: `alt_sel` presents the alternate-select register unchanged.
- R4: A change on `pad_in` becomes visible in the pin-level register two clock edges after it is applied, and not one edge after.
- R5: In edge mode (trigger-type bit 1), an edge-polarity bit of 1 selects the rising edge and 0 selects the falling edge. The pending bit sets on the third clock edge after the pin changes. It stays set when the pin returns to its old level, and it does not set on the opposite edge.
- R6: `irq` is high exactly when some pending bit has a mask bit of 0. A mask bit of 1 blocks that pin.
- R7: A write to the pending register ANDs the written data into it. Writing 0 clears every latched bit.
- R8: In level mode (trigger-type bit 0), a level-polarity bit of 1 selects active-high. The pending bit sets again on every edge while the level holds, so a clearing write has no effect during that time.
- R9: A level-polarity bit of 0 selects active-low. When a pin already sits at its active level, its pending bit sets on the edge after the write that puts it in level mode.
- R10: Pins whose direction bit is 1 never set their pending bit.
- R11: When a trigger hit and a clearing write land on the same edge, the pending bit ends up set.
- R12: A pin latches its pending bit even while its mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| pad_in | input | 16 | Raw pin levels |
| pad_out | output | 16 | Output data to pads |
| pad_oe | output | 16 | Per-pin output enable |
| alt_sel | output | 16 | Per-pin alternate-function select |
| irq | output | 1 | Summary interrupt |

## Verification
Register writes appear on reads and pad outputs one edge after the write strobe. Pin levels reach the level register two edges after `pad_in` changes. Edge triggers latch on the third edge. A level trigger enabled by a register write latches one edge after that write. Each check is queued with the cycle number in which its value is due. The monitor compares it at the falling clock edge of exactly that cycle. Where timing matters, the bench also reads the value one cycle early, to show the result is not yet there.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_DIR  = 4'd0,
        A_OUT  = 4'd1,
        A_LVL  = 4'd2,
        A_ALT  = 4'd3,
        A_MASK = 4'd4,
        A_TRIG = 4'd5,
        A_EPOL = 4'd6,
        A_LPOL = 4'd7,
        A_PEND = 4'd8
    } gpio_addr_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] trig_edge,
    input  logic [W-1:0] epol,
    input  logic [W-1:0] lpol,
    input  logic [W-1:0] is_out,
    output logic [W-1:0] hit
);
    typedef struct packed {
        logic [W-1:0] prev;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise_i, fall_i, edge_hit_i, lvl_hit_i;
        always_comb begin
            rise_i     = lvl[i] & ~st_q.prev[i];
            fall_i     = ~lvl[i] & st_q.prev[i];
            edge_hit_i = epol[i] ? rise_i : fall_i;
            lvl_hit_i  = (lvl[i] == lpol[i]);
            hit[i]     = ~is_out[i] & (trig_edge[i] ? edge_hit_i : lvl_hit_i);
        end
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      hit,
    input  logic [W-1:0]      pin_lvl,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      dout,
    output logic [W-1:0]      alt,
    output logic [W-1:0]      mask,
    output logic [W-1:0]      trig,
    output logic [W-1:0]      epol,
    output logic [W-1:0]      lpol,
    output logic [W-1:0]      pend
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dout;
        logic [W-1:0] alt;
        logic [W-1:0] mask;
        logic [W-1:0] trig;
        logic [W-1:0] epol;
        logic [W-1:0] lpol;
        logic [W-1:0] pend;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (addr)
                A_DIR:   r_d.dir  = wdata;
                A_OUT:   r_d.dout = wdata;
                A_ALT:   r_d.alt  = wdata;
                A_MASK:  r_d.mask = wdata;
                A_TRIG:  r_d.trig = wdata;
                A_EPOL:  r_d.epol = wdata;
                A_LPOL:  r_d.lpol = wdata;
                A_PEND:  r_d.pend = r_q.pend & wdata;
                default: ;
            endcase
        end
        // a fresh hit outranks a clearing write on the same edge
        r_d.pend = r_d.pend | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mask <= '1;
            r_q.trig <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (addr)
            A_DIR:   rdata = r_q.dir;
            A_OUT:   rdata = r_q.dout;
            A_LVL:   rdata = pin_lvl;
            A_ALT:   rdata = r_q.alt;
            A_MASK:  rdata = r_q.mask;
            A_TRIG:  rdata = r_q.trig;
            A_EPOL:  rdata = r_q.epol;
            A_LPOL:  rdata = r_q.lpol;
            A_PEND:  rdata = r_q.pend;
            default: rdata = '0;
        endcase
    end

    assign dir  = r_q.dir;
    assign dout = r_q.dout;
    assign alt  = r_q.alt;
    assign mask = r_q.mask;
    assign trig = r_q.trig;
    assign epol = r_q.epol;
    assign lpol = r_q.lpol;
    assign pend = r_q.pend;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPIN-1:0]   reg_wdata,
    output logic [NPIN-1:0]   reg_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   alt_sel,
    output logic              irq
);
    logic [NPIN-1:0] lvl, hit, dir, dout, alt, mask, trig, epol, lpol, pend;

    gpio_pin_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pad_in), .sync_out(lvl)
    );

    gpio_trig_detect #(.W(NPIN)) u_det (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .trig_edge(trig),
        .epol(epol), .lpol(lpol), .is_out(dir), .hit(hit)
    );

    gpio_bank_regs #(.W(NPIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .hit(hit), .pin_lvl(lvl), .rdata(reg_rdata),
        .dir(dir), .dout(dout), .alt(alt), .mask(mask), .trig(trig),
        .epol(epol), .lpol(lpol), .pend(pend)
    );

    assign pad_out = dout;
    assign pad_oe  = dir;
    assign alt_sel = alt;
    assign irq     = |(pend & ~mask);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [W-1:0]      reg_wdata,
    input logic [W-1:0]      pad_oe,
    input logic              irq,
    input logic [W-1:0]      pend_q,
    input logic [W-1:0]      mask_q,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      hit
);
    logic pend_wr;
    assign pend_wr = reg_wr && (reg_addr == A_PEND);

    p_dir_to_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DIR) |=> (pad_oe == $past(reg_wdata)));

    p_pend_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    p_all_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq);

    p_zero_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_wr && reg_wdata == '0 && hit == '0) |=> (pend_q == '0));

    p_out_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_wr |=> ((pend_q & ~$past(pend_q) & $past(dir_q)) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(NPIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pad_oe(pad_oe), .irq(irq), .pend_q(pend),
    .mask_q(mask), .dir_q(dir), .hit(hit)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/100ps
module gpio_irq_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe, alt_sel;
    logic        irq;

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        int          sel;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    gpio_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops items due in the current cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [15:0] act;
            it = sb.pop_front();
            case (it.sel)
                0:       act = reg_rdata;
                1:       act = {15'd0, irq};
                2:       act = pad_out;
                3:       act = pad_oe;
                default: act = alt_sel;
            endcase
            nchk++;
            if (it.due != cyc || act !== it.exp) begin
                nerr++;
                $display("FAIL %s: actual=%h expected=%h (due %0d, now %0d)",
                         it.tag, act, it.exp, it.due, cyc);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_now(int sel, logic [15:0] exp, string tag);
        item_t it;
        it.due = cyc; it.sel = sel; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd(logic [3:0] a, logic [15:0] exp, string tag);
        reg_addr = a;
        expect_now(0, exp, tag);
        tick();
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1 reset state
        expect_now(1, 16'h0, "R1 irq after reset");
        expect_now(3, 16'h0, "R1 pad_oe after reset");
        rd(4'd0, 16'h0000, "R1 dir reset");
        rd(4'd1, 16'h0000, "R1 out reset");
        rd(4'd3, 16'h0000, "R1 alt reset");
        rd(4'd4, 16'hFFFF, "R1 mask reset");
        rd(4'd5, 16'hFFFF, "R1 trig reset");
        rd(4'd6, 16'h0000, "R1 epol reset");
        rd(4'd7, 16'h0000, "R1 lpol reset");
        rd(4'd8, 16'h0000, "R1 pend reset");
        // R2 / R3 pad-facing registers
        wr(4'd0, 16'h00FF);
        wr(4'd1, 16'hA5A5);
        expect_now(3, 16'h00FF, "R2 pad_oe");
        expect_now(2, 16'hA5A5, "R2 pad_out");
        wr(4'd3, 16'h1234);
        expect_now(4, 16'h1234, "R3 alt_sel");
        rd(4'd1, 16'hA5A5, "R2 out readback");
        // R4 synchronizer latency
        wr(4'd0, 16'h0000);
        pad_in = 16'h5A3C;
        tick();
        rd(4'd2, 16'h0000, "R4 level one edge later");
        rd(4'd2, 16'h5A3C, "R4 level two edges later");
        // R5 falling edges (reset polarity), R12 latched while masked
        pad_in = 16'h0000;
        tick(); tick();
        rd(4'd8, 16'h0000, "R5 falling not yet");
        expect_now(1, 16'h0, "R12 irq blocked by mask");
        rd(4'd8, 16'h5A3C, "R5 R12 falling latched");
        // R7 AND semantics, then zero clear
        wr(4'd8, 16'hFF00);
        rd(4'd8, 16'h5A00, "R7 partial clear");
        wr(4'd8, 16'h0000);
        rd(4'd8, 16'h0000, "R7 zero clear");
        // R5 rising on pin 0, R6 unmasked irq
        wr(4'd6, 16'h0001);
        wr(4'd4, 16'hFFFE);
        pad_in[0] = 1'b1;
        tick(); tick();
        expect_now(1, 16'h0, "R6 irq before latch");
        rd(4'd8, 16'h0000, "R5 rising not yet");
        expect_now(1, 16'h1, "R6 irq raised");
        rd(4'd8, 16'h0001, "R5 rising latched");
        pad_in[0] = 1'b0;
        repeat (4) tick();
        rd(4'd8, 16'h0001, "R5 held, no falling set");
        wr(4'd8, 16'h0000);
        expect_now(1, 16'h0, "R6 irq after clear");
        rd(4'd8, 16'h0000, "R7 cleared pin0");
        // R11 hit and clear on the same edge
        pad_in[0] = 1'b1;
        tick(); tick();
        wr(4'd8, 16'h0000);
        rd(4'd8, 16'h0001, "R11 hit beats clear");
        pad_in[0] = 1'b0;
        repeat (3) tick();
        wr(4'd8, 16'h0000);
        rd(4'd8, 16'h0000, "R11 cleared afterwards");
        // R8 level high on pin 2
        wr(4'd7, 16'h0004);
        wr(4'd5, 16'hFFFB);
        rd(4'd8, 16'h0000, "R8 inactive level");
        pad_in[2] = 1'b1;
        tick(); tick();
        rd(4'd8, 16'h0000, "R8 not yet");
        rd(4'd8, 16'h0004, "R8 level high latched");
        wr(4'd8, 16'h0000);
        rd(4'd8, 16'h0004, "R8 clear ignored while active");
        pad_in[2] = 1'b0;
        repeat (3) tick();
        wr(4'd8, 16'h0000);
        rd(4'd8, 16'h0000, "R8 clear after release");
        // R9 level low on pin 3, armed by the config write
        wr(4'd5, 16'hFFF3);
        rd(4'd8, 16'h0000, "R9 same edge as write");
        rd(4'd8, 16'h0008, "R9 one edge after write");
        pad_in[3] = 1'b1;
        repeat (3) tick();
        wr(4'd8, 16'h0000);
        rd(4'd8, 16'h0000, "R9 released and cleared");
        // R10 output pin does not trigger
        wr(4'd0, 16'h0010);
        wr(4'd6, 16'h0011);
        pad_in[4] = 1'b1;
        repeat (4) tick();
        rd(4'd8, 16'h0000, "R10 output pin quiet");
        rd(4'd2, 16'h0018, "R4 level shows pins 3 and 4");
        tick(); tick();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL all: watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule